// File: doc/BRIEF.md
# Sigma-Delta Conversion and Calibration Sequencer

This block is the timing controller for a sigma-delta converter. It runs on the master input clock. It decides when free-running conversions and the three calibration routines start and how long they last. It also drives the active-low data-ready flag that a host polls before it reads a result. The modulator, the filter arithmetic, the coefficient calculation and the serial port sit outside the block. They receive its strobes: one updates the data register, and two tagged step strobes tell the offset/gain register pair of the selected channel to latch a new coefficient.

All activity is gated by a frame-sync input. While frame-sync is high, nothing runs. A falling edge starts a conversion or calibration sequence in the mode held in the two live mode bits. A setup write that carries calibration bits while frame-sync is already low also starts a sequence. The mode bits clear to normal when a calibration completes.

The output-word period is an input counted in master clocks. It is sampled when a sequence is triggered. Every duration is counted in master clocks from the trigger edge, which is the rising clock edge at which the falling frame-sync or the setup write is first sampled. "Edge K" means the K-th rising edge after that trigger edge, and outputs hold their new value from that edge onwards.

Top module: `sd_cal_sequencer`

## Requirements
- R1: After reset, drdy_n is 1, mode_bits is 00, and data_upd, zs_done and fs_done are 0.
- R2: While fsync is sampled high, no data_upd, zs_done or fs_done pulse is produced.
- R3: In mode 00, data_upd pulses and drdy_n falls at edge 3T after the trigger, where T is the period. Further results follow every T cycles while fsync stays low.
- R4: A one-cycle read_done pulse sets drdy_n to 1 at the next edge, unless a forced-high interval is running, in which case the pulse has no effect.
- R5: When a result arrives while drdy_n is still 0 and no read_done is present, drdy_n is driven to 1 for exactly 500 cycles and then returns to 0.
- R6: Raising fsync leaves a low drdy_n low. A later fsync falling edge sets drdy_n to 1 at the trigger edge.
- R7: Mode 01 (self-calibration) pulses zs_done at edge 3T. At edge 6T it pulses fs_done and clears mode_bits to 00. The first result arrives at edge 9T+2000.
- R8: Mode 10 pulses zs_done only, and mode 11 pulses fs_done only, each at edge 3T with mode_bits cleared to 00 at that edge. The first result arrives at edge 4T+2000. zs_done and fs_done are never high together.
- R9: A setup write of a non-zero mode while fsync is low restarts the sequence in that mode, timed from the write's edge. A setup write of 00 only updates mode_bits.
- R10: Raising fsync during a calibration abandons it without changing mode_bits. The next fsync falling edge runs the full sequence from its start.
- R11: T is captured at the trigger edge. Later changes on word_period do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync; high holds the sequencer idle |
| setup_wr | input | 1 | One-cycle setup-register write strobe |
| setup_mode | input | 2 | Mode bits carried by the write: 00 normal, 01 self, 10 zero-scale system, 11 full-scale system |
| read_done | input | 1 | One-cycle strobe: a data-register read has completed |
| word_period | input | PERIOD_W | Output-word period in master clocks |
| drdy_n | output | 1 | Data-ready flag, active low |
| mode_bits | output | 2 | Live mode bits, cleared when a calibration completes |
| data_upd | output | 1 | One-cycle data-register update strobe |
| zs_done | output | 1 | One-cycle strobe at the end of a zero-scale step |
| fs_done | output | 1 | One-cycle strobe at the end of a full-scale step |

## Verification
The assertions assume that every input is synchronous to the master clock. They also assume that read_done and setup_wr are single-cycle pulses and that word_period is at least 1000 whenever a sequence is triggered. That minimum guarantees the 500-cycle forced-high interval ends before the next result can arrive. The stimulus uses only periods of 1000 and 1300, drives every strobe for exactly one clock at the falling clock edge, and changes word_period only after a trigger, to show that the captured value is used.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

   typedef enum logic [1:0] {
      MODE_NORM = 2'b00,
      MODE_SELF = 2'b01,
      MODE_ZERO = 2'b10,
      MODE_FULL = 2'b11
   } cal_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CAL,
      ST_PIPE,
      ST_CONV
   } seq_state_e;

endpackage

// File: rtl/sdseq_down_timer.sv
module sdseq_down_timer #(
   parameter int unsigned SPAN = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic cancel,
   output logic expired,
   output logic busy
);

   localparam int unsigned CW = $clog2(SPAN);
   localparam logic [CW-1:0] LOAD_VAL = CW'(SPAN - 1);

   generate
      if (SPAN < 2) begin : g_bad_span
         $error("sdseq_down_timer: SPAN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (cancel) begin
         busy_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= LOAD_VAL;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign expired = busy_q && (cnt_q == '0);
   assign busy    = busy_q;

endmodule

// File: rtl/sdseq_word_timer.sv
module sdseq_word_timer #(
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned MIN_PERIOD = 1000,
   parameter int unsigned WCNT_W     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  logic                rephase,
   input  logic [PERIOD_W-1:0] period_in,
   output logic                tick,
   output logic [WCNT_W-1:0]   wcnt
);

   localparam logic [WCNT_W-1:0] WCNT_MAX = '1;

   generate
      if (MIN_PERIOD >= (1 << PERIOD_W)) begin : g_bad_width
         $error("sdseq_word_timer: PERIOD_W too narrow for MIN_PERIOD");
      end
   endgenerate

   logic [PERIOD_W-1:0] per_q;
   logic [PERIOD_W-1:0] pcnt_q;
   logic [WCNT_W-1:0]   wcnt_q;

   assign tick = run && (pcnt_q == per_q - 1'b1);
   assign wcnt = wcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= '0;
         pcnt_q <= '0;
         wcnt_q <= '0;
      end else if (restart) begin
         per_q  <= period_in;
         pcnt_q <= '0;
         wcnt_q <= '0;
      end else if (rephase) begin
         pcnt_q <= '0;
      end else if (run) begin
         if (tick) begin
            pcnt_q <= '0;
            if (wcnt_q != WCNT_MAX) wcnt_q <= wcnt_q + 1'b1;
         end else begin
            pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end

   // R11
   period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (period_in >= PERIOD_W'(MIN_PERIOD)));

endmodule

// File: rtl/sdseq_ready_flag.sv
module sdseq_ready_flag #(
   parameter int unsigned BLANK_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic result,
   input  logic read_done,
   input  logic release_hi,
   output logic drdy_n
);

   logic drdy_q;
   logic blank_load;
   logic blank_exp;
   logic blanking;

   assign blank_load = !release_hi && result && !drdy_q && !read_done;

   sdseq_down_timer #(.SPAN(BLANK_CYC)) u_blank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (blank_load),
      .cancel  (release_hi),
      .expired (blank_exp),
      .busy    (blanking)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              drdy_q <= 1'b1;
      else if (release_hi)     drdy_q <= 1'b1;
      else if (result)         drdy_q <= blank_load;
      else if (blanking) begin
         if (blank_exp)        drdy_q <= 1'b0;
      end
      else if (read_done)      drdy_q <= 1'b1;
   end

   assign drdy_n = drdy_q;

   // R4
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (read_done && !blanking && !result && !release_hi) |=> drdy_n);

   // R3
   fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_n) |-> ($past(result) || $past(blank_exp)));

endmodule

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
   import sdseq_pkg::*;
#(
   parameter int unsigned PIPE_CYC     = 2000,
   parameter int unsigned SETTLE_WORDS = 3,
   parameter int unsigned STEP_WORDS   = 3,
   parameter int unsigned SYS_WORDS    = 4,
   parameter int unsigned SELF_WORDS   = 9,
   parameter int unsigned WCNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  cal_mode_e         start_mode,
   input  logic              tick,
   input  logic [WCNT_W-1:0] wcnt,
   output logic              rephase,
   output logic              evt_result,
   output logic              evt_clr,
   output logic              data_upd,
   output logic              zs_done,
   output logic              fs_done
);

   localparam logic [WCNT_W-1:0] SETTLE_LAST = WCNT_W'(SETTLE_WORDS - 1);
   localparam logic [WCNT_W-1:0] STEP1_LAST  = WCNT_W'(STEP_WORDS - 1);
   localparam logic [WCNT_W-1:0] STEP2_LAST  = WCNT_W'(2 * STEP_WORDS - 1);
   localparam logic [WCNT_W-1:0] SYS_LAST    = WCNT_W'(SYS_WORDS - 1);
   localparam logic [WCNT_W-1:0] SELF_LAST   = WCNT_W'(SELF_WORDS - 1);

   generate
      if (SYS_WORDS <= STEP_WORDS || SELF_WORDS <= 2 * STEP_WORDS) begin : g_bad_order
         $error("sdseq_ctrl: pipeline entry must follow the last step");
      end
      if (SELF_WORDS >= (1 << WCNT_W)) begin : g_bad_wcnt
         $error("sdseq_ctrl: WCNT_W too narrow");
      end
   endgenerate

   seq_state_e state_q, state_d;
   cal_mode_e  cmode_q;
   logic       enter_pipe;
   logic       pipe_exp;
   logic       pipe_busy;
   logic       evt_zs, evt_fs;

   sdseq_down_timer #(.SPAN(PIPE_CYC)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (enter_pipe),
      .cancel  (!run || start),
      .expired (pipe_exp),
      .busy    (pipe_busy)
   );

   always_comb begin
      state_d    = state_q;
      evt_result = 1'b0;
      evt_zs     = 1'b0;
      evt_fs     = 1'b0;
      evt_clr    = 1'b0;
      enter_pipe = 1'b0;
      rephase    = 1'b0;
      if (!run) begin
         state_d = ST_IDLE;
      end else if (start) begin
         state_d = (start_mode == MODE_NORM) ? ST_SETTLE : ST_CAL;
      end else begin
         case (state_q)
            ST_SETTLE: begin
               if (tick && wcnt == SETTLE_LAST) begin
                  evt_result = 1'b1;
                  state_d    = ST_CONV;
               end
            end
            ST_CONV: begin
               evt_result = tick;
            end
            ST_CAL: begin
               if (tick) begin
                  if (cmode_q == MODE_SELF) begin
                     evt_zs = (wcnt == STEP1_LAST);
                     if (wcnt == STEP2_LAST) begin
                        evt_fs  = 1'b1;
                        evt_clr = 1'b1;
                     end
                     if (wcnt == SELF_LAST) begin
                        enter_pipe = 1'b1;
                        state_d    = ST_PIPE;
                     end
                  end else begin
                     if (wcnt == STEP1_LAST) begin
                        evt_zs  = (cmode_q == MODE_ZERO);
                        evt_fs  = (cmode_q == MODE_FULL);
                        evt_clr = 1'b1;
                     end
                     if (wcnt == SYS_LAST) begin
                        enter_pipe = 1'b1;
                        state_d    = ST_PIPE;
                     end
                  end
               end
            end
            ST_PIPE: begin
               if (pipe_exp) begin
                  evt_result = 1'b1;
                  rephase    = 1'b1;
                  state_d    = ST_CONV;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cmode_q  <= MODE_NORM;
         data_upd <= 1'b0;
         zs_done  <= 1'b0;
         fs_done  <= 1'b0;
      end else begin
         state_q  <= state_d;
         if (start) cmode_q <= start_mode;
         data_upd <= evt_result;
         zs_done  <= evt_zs;
         fs_done  <= evt_fs;
      end
   end

   // R8
   tag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({zs_done, fs_done}));

   // R10
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (state_q == ST_IDLE));

   // R7
   pipe_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_busy |-> (state_q == ST_PIPE));

endmodule

// File: rtl/sd_cal_sequencer.sv
module sd_cal_sequencer
   import sdseq_pkg::*;
#(
   parameter int unsigned PERIOD_W     = 16,
   parameter int unsigned MIN_PERIOD   = 1000,
   parameter int unsigned PIPE_CYC     = 2000,
   parameter int unsigned BLANK_CYC    = 500,
   parameter int unsigned SETTLE_WORDS = 3,
   parameter int unsigned STEP_WORDS   = 3,
   parameter int unsigned SYS_WORDS    = 4,
   parameter int unsigned SELF_WORDS   = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fsync,
   input  logic                setup_wr,
   input  logic [1:0]          setup_mode,
   input  logic                read_done,
   input  logic [PERIOD_W-1:0] word_period,
   output logic                drdy_n,
   output logic [1:0]          mode_bits,
   output logic                data_upd,
   output logic                zs_done,
   output logic                fs_done
);

   localparam int unsigned WCNT_W = $clog2(SELF_WORDS + 1);

   generate
      if (BLANK_CYC >= MIN_PERIOD) begin : g_bad_blank
         $error("sd_cal_sequencer: forced-high interval must be shorter than the minimum period");
      end
   endgenerate

   logic              fsync_q;
   logic              fall;
   logic              wr_cal;
   logic              start;
   logic              run;
   cal_mode_e         mode_q;
   cal_mode_e         start_mode;
   logic              tick;
   logic [WCNT_W-1:0] wcnt;
   logic              rephase;
   logic              evt_result;
   logic              evt_clr;

   assign run        = !fsync;
   assign fall       = fsync_q && !fsync;
   assign wr_cal     = setup_wr && (setup_mode != 2'b00) && !fsync;
   assign start      = fall || wr_cal;
   assign start_mode = setup_wr ? cal_mode_e'(setup_mode) : mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsync_q <= 1'b1;
         mode_q  <= MODE_NORM;
      end else begin
         fsync_q <= fsync;
         if (setup_wr)     mode_q <= cal_mode_e'(setup_mode);
         else if (evt_clr) mode_q <= MODE_NORM;
      end
   end

   assign mode_bits = mode_q;

   sdseq_word_timer #(
      .PERIOD_W   (PERIOD_W),
      .MIN_PERIOD (MIN_PERIOD),
      .WCNT_W     (WCNT_W)
   ) u_words (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .restart   (start),
      .rephase   (rephase),
      .period_in (word_period),
      .tick      (tick),
      .wcnt      (wcnt)
   );

   sdseq_ctrl #(
      .PIPE_CYC     (PIPE_CYC),
      .SETTLE_WORDS (SETTLE_WORDS),
      .STEP_WORDS   (STEP_WORDS),
      .SYS_WORDS    (SYS_WORDS),
      .SELF_WORDS   (SELF_WORDS),
      .WCNT_W       (WCNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .start      (start),
      .start_mode (start_mode),
      .tick       (tick),
      .wcnt       (wcnt),
      .rephase    (rephase),
      .evt_result (evt_result),
      .evt_clr    (evt_clr),
      .data_upd   (data_upd),
      .zs_done    (zs_done),
      .fs_done    (fs_done)
   );

   sdseq_ready_flag #(.BLANK_CYC(BLANK_CYC)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .result     (evt_result),
      .read_done  (read_done),
      .release_hi (fall),
      .drdy_n     (drdy_n)
   );

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fsync) |-> (!data_upd && !zs_done && !fs_done));

   // R6
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !drdy_n && !read_done) |=> !drdy_n);

   // R7
   mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_bits != 2'b00) && !setup_wr) |=>
         ((mode_bits == $past(mode_bits)) || zs_done || fs_done));

endmodule

// File: tb/sim_sd_cal_sequencer.sv
`timescale 1ns/1ps
module sim_sd_cal_sequencer;

   localparam int PIPE  = 2000;
   localparam int BLANK = 500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b1;
   logic        setup_wr = 1'b0;
   logic [1:0]  setup_mode = 2'b00;
   logic        read_done = 1'b0;
   logic [15:0] word_period = 16'd1000;
   logic        drdy_n;
   logic [1:0]  mode_bits;
   logic        data_upd, zs_done, fs_done;

   int    checks = 0;
   int    bad = 0;
   bit    fin = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   sd_cal_sequencer u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsync       (fsync),
      .setup_wr    (setup_wr),
      .setup_mode  (setup_mode),
      .read_done   (read_done),
      .word_period (word_period),
      .drdy_n      (drdy_n),
      .mode_bits   (mode_bits),
      .data_upd    (data_upd),
      .zs_done     (zs_done),
      .fs_done     (fs_done)
   );

   // Behavioural reference: absolute due-cycles for every scheduled event.
   longint     cyc;
   bit         act, pfs;
   int         per_m;
   logic [1:0] mm;
   longint     t_res, t_zs, t_fs, t_clr, t_blank;
   bit         e_drdy, e_blank, e_upd, e_zs, e_fs;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc = 0; act = 0; pfs = 1; per_m = 0; mm = 2'b00;
         t_res = -1; t_zs = -1; t_fs = -1; t_clr = -1; t_blank = -1;
         e_drdy = 1; e_blank = 0; e_upd = 0; e_zs = 0; e_fs = 0;
      end else begin : mdl
         bit fl, st, r, c;
         logic [1:0] em;
         cyc++;
         fl = pfs && !fsync;
         st = fl || (setup_wr && setup_mode != 2'b00 && !fsync);
         em = setup_wr ? setup_mode : mm;
         r = 0; c = 0; e_upd = 0; e_zs = 0; e_fs = 0;
         if (fsync) act = 0;
         if (st) begin
            act = 1; per_m = int'(word_period);
            t_res = -1; t_zs = -1; t_fs = -1; t_clr = -1;
            case (em)
               2'b00: t_res = cyc + 3 * per_m;
               2'b01: begin
                  t_zs = cyc + 3 * per_m; t_fs = cyc + 6 * per_m;
                  t_clr = t_fs; t_res = cyc + 9 * per_m + PIPE;
               end
               2'b10: begin t_zs = cyc + 3 * per_m; t_clr = t_zs; t_res = cyc + 4 * per_m + PIPE; end
               default: begin t_fs = cyc + 3 * per_m; t_clr = t_fs; t_res = cyc + 4 * per_m + PIPE; end
            endcase
         end else if (act) begin
            if (cyc == t_res) begin r = 1; t_res = cyc + per_m; end
            if (cyc == t_zs)  e_zs = 1;
            if (cyc == t_fs)  e_fs = 1;
            if (cyc == t_clr) c = 1;
         end
         e_upd = r;
         if (setup_wr) mm = setup_mode;
         else if (c)   mm = 2'b00;
         if (fl) begin e_drdy = 1; e_blank = 0; end
         else if (r) begin
            if (!e_drdy && !read_done) begin e_drdy = 1; e_blank = 1; t_blank = cyc + BLANK; end
            else begin e_drdy = 0; e_blank = 0; end
         end else if (e_blank) begin
            if (cyc == t_blank) begin e_drdy = 0; e_blank = 0; end
         end else if (read_done) e_drdy = 1;
         pfs = fsync;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         checks++;
         if ({drdy_n, mode_bits, data_upd, zs_done, fs_done} !== {e_drdy, mm, e_upd, e_zs, e_fs}) begin
            bad++;
            $display("FAIL %s cycle %0d {drdy_n,mode,upd,zs,fs} act=%b exp=%b", cur_req, cyc,
                     {drdy_n, mode_bits, data_upd, zs_done, fs_done}, {e_drdy, mm, e_upd, e_zs, e_fs});
         end
      end
   end

   task automatic chk(bit ok, string tag, int act_v, int exp_v);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act_v, exp_v);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_read();
      read_done = 1'b1; @(negedge clk); read_done = 1'b0;
   endtask

   task automatic write_mode(logic [1:0] m);
      setup_mode = m; setup_wr = 1'b1; @(negedge clk); setup_wr = 1'b0;
   endtask

   task automatic finish_up();
      if (!fin) begin
         fin = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_up();
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1 reset state
      chk(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
      chk(mode_bits == 2'b00, "R1 mode_bits", mode_bits, 0);
      chk({data_upd, zs_done, fs_done} == 3'b000, "R1 strobes", {data_upd, zs_done, fs_done}, 0);

      // R3 normal conversion, R4 read, R5 forced-high interval
      cur_req = "R3";
      fsync = 1'b0;
      wait_cyc(3010);
      chk(drdy_n == 1'b0, "R3 first result", drdy_n, 0);
      cur_req = "R4";
      pulse_read();
      chk(drdy_n == 1'b1, "R4 read release", drdy_n, 1);
      cur_req = "R5";
      wait_cyc(2200);
      wait_cyc(600);
      pulse_read();

      // R6 hold low across fsync rise, release on fall
      cur_req = "R6";
      wait_cyc(1000);
      fsync = 1'b1;
      wait_cyc(200);
      chk(drdy_n == 1'b0, "R6 held low", drdy_n, 0);
      cur_req = "R2";
      wait_cyc(3000);
      chk(drdy_n == 1'b0, "R2 idle no update", drdy_n, 0);
      cur_req = "R6";
      fsync = 1'b0;
      wait_cyc(1);
      chk(drdy_n == 1'b1, "R6 fall release", drdy_n, 1);
      wait_cyc(100);
      fsync = 1'b1;

      // R7 self-calibration
      cur_req = "R7";
      write_mode(2'b01);
      chk(mode_bits == 2'b01, "R7 mode written", mode_bits, 1);
      fsync = 1'b0;
      wait_cyc(12500);
      chk(mode_bits == 2'b00, "R7 mode cleared", mode_bits, 0);
      pulse_read();
      fsync = 1'b1;

      // R8 zero-scale then full-scale system calibration
      cur_req = "R8";
      write_mode(2'b10);
      fsync = 1'b0;
      wait_cyc(6500);
      chk(mode_bits == 2'b00, "R8 zero-scale clear", mode_bits, 0);
      fsync = 1'b1;
      write_mode(2'b11);
      fsync = 1'b0;
      wait_cyc(6500);
      chk(mode_bits == 2'b00, "R8 full-scale clear", mode_bits, 0);
      pulse_read();

      // R9 calibration started by a setup write while fsync is low
      cur_req = "R9";
      wait_cyc(300);
      write_mode(2'b00);
      wait_cyc(50);
      write_mode(2'b10);
      wait_cyc(6500);
      chk(mode_bits == 2'b00, "R9 write-start clear", mode_bits, 0);

      // R10 abort mid-calibration, restart from the beginning
      cur_req = "R10";
      fsync = 1'b1;
      write_mode(2'b01);
      fsync = 1'b0;
      wait_cyc(4000);
      fsync = 1'b1;
      wait_cyc(300);
      chk(mode_bits == 2'b01, "R10 mode kept", mode_bits, 1);
      fsync = 1'b0;
      wait_cyc(12500);
      chk(mode_bits == 2'b00, "R10 rerun cleared", mode_bits, 0);

      // R11 period captured at trigger
      cur_req = "R11";
      fsync = 1'b1;
      word_period = 16'd1300;
      wait_cyc(20);
      fsync = 1'b0;
      wait_cyc(5);
      word_period = 16'd1000;
      wait_cyc(3910);
      chk(drdy_n == 1'b0, "R11 first result at 3x1300", drdy_n, 0);
      wait_cyc(1500);
      fsync = 1'b1;
      wait_cyc(10);
      finish_up();
   end

endmodule